// File: doc/BRIEF.md
# Configurable sum-of-products logic array

This block evaluates sum-of-products functions of `N_IN` plain logic inputs onto `N_OUT` combinational outputs. A configuration map held in flops plays the part of a fuse array: a set bit keeps a connection and a cleared bit removes it. The map is loaded one bit per clock through a serial port. While it is loaded, the previous map leaves through a serial output, which gives readback.

A parameter selects one of three array styles. In the decoder-ROM style, the product plane is a fixed full decoder of all `2**N_IN` minterms, and only the sum plane comes from the map. In the two-plane style, both the product plane and the sum plane come from the map, so one product term can feed any number of outputs. In the fixed-sum style, only the product plane comes from the map. Each output then ORs its own private group of `N_TERM/N_OUT` terms, and no term is shared.

Every input reaches the product plane twice, once as its true value and once as its complement.

Top module: `sop_array`

## Requirements
- R1: Each product term has `2*N_IN` literal bits. Bit `2*i` connects input `i` and bit `2*i+1` connects its complement. Term `t` uses map bits `t*2*N_IN` upward. A term is the AND of its connected literals.
- R2: In the two-plane style (`ARCH_PLA`), sum-plane bit `AND_W + t*N_OUT + j` connects term `t` to output `j`. One term may feed several outputs.
- R3: In the fixed-sum style (`ARCH_PAL`), output `j` is the OR of terms `j*G` to `j*G+G-1`, where `G = N_TERM/N_OUT`. There are no sum-plane bits.
- R4: In the decoder-ROM style (`ARCH_ROM`), term `t` is true exactly when `data_i == t`. The map holds only sum bits, and the word for address `t` sits at bits `t*N_OUT` upward, with bit `j` driving `data_o[j]`.
- R5: A term with both a literal and its complement connected is always 0.
- R6: A term with no literal connected is 0. Reset clears the whole map, so every output is 0 for any input after reset.
- R7: Loading works as follows:
  - While `load_en_i` is 1, each clock shifts `cfg_bit_i` in and moves the map one place toward bit 0.
  - After `CFG_W` shifts, the k-th bit sent sits at index k, so product-plane bits are sent before sum-plane bits.
  - Extra shifts move the map further toward bit 0.
- R8: While `load_en_i` is 1, `data_o` is 0. The new map drives the outputs only after `load_en_i` falls.
- R9: `cfg_bit_o` shows map bit 0, the bit that the next shift drops. During a full reload, the old map therefore appears in its original load order.
- R10: With `load_en_i` at 0, `cfg_bit_i` is ignored, the map holds, and outputs change only when `data_i` changes.
- R11: With two inputs (`data_i[1]` = A, `data_i[0]` = B) and four outputs, the array can realise the following functions, with F1 at `data_o[3]`:
  - F1 = NOT A
  - F2 = A OR B
  - F3 = A NAND B
  - F4 = A XOR B
  
  For A,B = 00, 01, 10 and 11 the outputs read 0xA, 0xF, 0x7 and 0x4. In the decoder-ROM style this is the stored words for addresses 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the map flops |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en_i | input | 1 | Shift enable for the configuration map |
| cfg_bit_i | input | 1 | Serial configuration bit in |
| cfg_bit_o | output | 1 | Serial readback, map bit 0 |
| data_i | input | N_IN | Logic inputs |
| data_o | output | N_OUT | Sum-of-products outputs |

## Verification
The hardest case to reach from the ports is a term that is connected but meaningless. A self-contradicting term or an empty term cannot be seen directly: it only shows up as a 1 that is missing from an output that other terms also feed. To expose this, the bench reloads a known two-plane map with a single term changed to hold both A and NOT A. That term is shared between two outputs. The bench compares the outputs against values worked out with the term removed, and uses the same reload to capture the readback stream of the earlier map. Bit ordering is checked by sending extra shifts into the decoder-ROM map, which moves every stored word down by one address.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
  typedef enum logic [1:0] {
    ARCH_ROM = 2'd0,
    ARCH_PLA = 2'd1,
    ARCH_PAL = 2'd2
  } arch_e;
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_en_i,
  input  logic           bit_i,
  output logic           bit_o,
  output logic [LEN-1:0] map_o
);
  logic [LEN-1:0] map_q;
  logic [LEN-1:0] map_d;
  logic [LEN-1:0] shifted;

  generate
    if (LEN > 1) begin : g_wide
      assign shifted = {bit_i, map_q[LEN-1:1]};
    end else begin : g_single
      assign shifted = bit_i;
    end
  endgenerate

  always_comb begin
    map_d = map_q;
    if (shift_en_i) map_d = shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_d;
  end

  assign bit_o = map_q[0];
  assign map_o = map_q;
endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
  parameter int unsigned N_IN   = 2,
  parameter int unsigned N_TERM = 6,
  localparam int unsigned N_LIT = 2 * N_IN,
  localparam int unsigned FW    = N_TERM * N_LIT
) (
  input  logic [N_IN-1:0]   data_i,
  input  logic [FW-1:0]     fuse_i,
  output logic [N_TERM-1:0] term_o
);
  logic [N_LIT-1:0] lit;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[2*i]   = data_i[i];
      assign lit[2*i+1] = ~data_i[i];
    end
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_LIT-1:0] conn;
      assign conn      = fuse_i[t*N_LIT +: N_LIT];
      assign term_o[t] = (|conn) & (&(~conn | lit));
    end
  endgenerate
endmodule

// File: rtl/sop_minterm_dec.sv
module sop_minterm_dec #(
  parameter int unsigned N_IN = 2,
  localparam int unsigned N_MT = 2 ** N_IN
) (
  input  logic [N_IN-1:0] data_i,
  output logic [N_MT-1:0] term_o
);
  generate
    for (genvar t = 0; t < N_MT; t++) begin : g_mt
      assign term_o[t] = (data_i == N_IN'(t));
    end
  endgenerate
endmodule

// File: rtl/sop_sum_plane.sv
module sop_sum_plane #(
  parameter int unsigned N_TERM = 6,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned FW    = N_TERM * N_OUT
) (
  input  logic [N_TERM-1:0] term_i,
  input  logic [FW-1:0]     fuse_i,
  output logic [N_OUT-1:0]  sum_o
);
  generate
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
      logic [N_TERM-1:0] col;
      for (genvar t = 0; t < N_TERM; t++) begin : g_col
        assign col[t] = fuse_i[t*N_OUT + j];
      end
      assign sum_o[j] = |(term_i & col);
    end
  endgenerate
endmodule

// File: rtl/sop_sum_fixed.sv
module sop_sum_fixed #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned GRP   = N_TERM / N_OUT
) (
  input  logic [N_TERM-1:0] term_i,
  output logic [N_OUT-1:0]  sum_o
);
  generate
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
      assign sum_o[j] = |term_i[j*GRP +: GRP];
    end
  endgenerate
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
#(
  parameter arch_e       ARCH   = ARCH_PLA,
  parameter int unsigned N_IN   = 2,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned N_TERM = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             cfg_bit_i,
  output logic             cfg_bit_o,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] data_o
);
  localparam int unsigned N_LIT = 2 * N_IN;
  localparam int unsigned N_PT  = (ARCH == ARCH_ROM) ? (2 ** N_IN) : N_TERM;
  localparam int unsigned AND_W = (ARCH == ARCH_ROM) ? 0 : N_PT * N_LIT;
  localparam int unsigned OR_W  = (ARCH == ARCH_PAL) ? 0 : N_PT * N_OUT;
  localparam int unsigned CFG_W = AND_W + OR_W;

  logic             rst_sync_n;
  logic [CFG_W-1:0] map_q;
  logic [N_PT-1:0]  term_w;
  logic [N_OUT-1:0] sum_w;
  logic [N_OUT-1:0] out_d;

  sop_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  sop_cfg_chain #(.LEN(CFG_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .shift_en_i (load_en_i),
    .bit_i      (cfg_bit_i),
    .bit_o      (cfg_bit_o),
    .map_o      (map_q)
  );

  generate
    if (ARCH == ARCH_ROM) begin : g_dec
      sop_minterm_dec #(.N_IN(N_IN)) u_and (
        .data_i (data_i),
        .term_o (term_w)
      );
    end else begin : g_prog_and
      sop_term_plane #(.N_IN(N_IN), .N_TERM(N_PT)) u_and (
        .data_i (data_i),
        .fuse_i (map_q[AND_W-1:0]),
        .term_o (term_w)
      );
    end

    if (ARCH == ARCH_PAL) begin : g_fixed_or
      sop_sum_fixed #(.N_TERM(N_PT), .N_OUT(N_OUT)) u_or (
        .term_i (term_w),
        .sum_o  (sum_w)
      );
    end else begin : g_prog_or
      sop_sum_plane #(.N_TERM(N_PT), .N_OUT(N_OUT)) u_or (
        .term_i (term_w),
        .fuse_i (map_q[CFG_W-1:AND_W]),
        .sum_o  (sum_w)
      );
    end
  endgenerate

  // Partially shifted maps never reach the pins.
  always_comb begin
    out_d = sum_w;
    if (load_en_i) out_d = '0;
  end

  assign data_o = out_d;
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
  import sop_array_pkg::*;
#(
  parameter arch_e       ARCH  = ARCH_PLA,
  parameter int unsigned N_IN  = 2,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned N_PT  = 6,
  parameter int unsigned CFG_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_en_i,
  input logic [N_IN-1:0]  data_i,
  input logic [N_OUT-1:0] data_o,
  input logic [CFG_W-1:0] map_i,
  input logic [N_PT-1:0]  term_i
);
  AST_LOAD_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |-> (data_o == '0));                                            // R8
  AST_MAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(map_i));                                           // R10
  AST_EMPTY_MAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_i == '0) |-> (data_o == '0));                                        // R6
  AST_OUT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && $past(!load_en_i) && $stable(data_i)) |-> $stable(data_o)); // R10

  generate
    if (ARCH == ARCH_ROM) begin : g_rom_chk
      AST_ONE_MINTERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(term_i) == 1);                                             // R4
    end
  endgenerate
endmodule

bind sop_array sop_array_chk #(
  .ARCH  (ARCH),
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .N_PT  (N_PT),
  .CFG_W (CFG_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_i (load_en_i),
  .data_i    (data_i),
  .data_o    (data_o),
  .map_i     (map_q),
  .term_i    (term_w)
);

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;
  import sop_array_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [1:0] din;
  logic [2:0] ld;
  logic [2:0] cin;
  logic [2:0] cout;
  logic [3:0] dout [3];
  int n_chk;
  int n_bad;

  // Index 0: two-plane, 1: decoder ROM, 2: fixed sum
  localparam logic [47:0] PLA_MAP = {
    4'b0001, 4'b0001, 4'b0010, 4'b0100, 4'b0100, 4'b1010,
    4'b1001, 4'b0110, 4'b0010, 4'b0001, 4'b0100, 4'b1000};
  localparam logic [47:0] PLA_BAD = {
    4'b0001, 4'b0001, 4'b0010, 4'b0100, 4'b0100, 4'b1010,
    4'b1001, 4'b0110, 4'b0010, 4'b0001, 4'b0100, 4'b1100};
  localparam logic [15:0] ROM_MAP = {4'h4, 4'h7, 4'hF, 4'hA};
  localparam logic [31:0] PAL_MAP = {
    4'b0000, 4'b1000, 4'b0001, 4'b0100,
    4'b0010, 4'b1000, 4'b1001, 4'b0110};

  // {A,B, expected F1..F4}
  localparam logic [5:0] VEC [4] = '{
    {2'b00, 4'hA}, {2'b01, 4'hF}, {2'b10, 4'h7}, {2'b11, 4'h4}};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sop_array #(.ARCH(ARCH_PLA), .N_TERM(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(ld[0]), .cfg_bit_i(cin[0]),
    .cfg_bit_o(cout[0]), .data_i(din), .data_o(dout[0]));
  sop_array #(.ARCH(ARCH_ROM), .N_TERM(4)) dut_rom_i (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(ld[1]), .cfg_bit_i(cin[1]),
    .cfg_bit_o(cout[1]), .data_i(din), .data_o(dout[1]));
  sop_array #(.ARCH(ARCH_PAL), .N_TERM(8)) dut_pal_i (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(ld[2]), .cfg_bit_i(cin[2]),
    .cfg_bit_o(cout[2]), .data_i(din), .data_o(dout[2]));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic load_map(input int which, input logic [63:0] m, input int len,
                          output logic [63:0] rb);
    rb = '0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      ld[which]  = 1'b1;
      cin[which] = m[k];
      rb[k]      = cout[which];
    end
    @(negedge clk);
    din = 2'b01;
    #1;
    check("R8 outputs blank at end of load", 64'(dout[which]), 64'h0);
    ld[which] = 1'b0;
    cin[which] = 1'b0;
  endtask

  task automatic apply(input logic [1:0] v);
    @(negedge clk);
    din = v;
    #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [63:0] rb;
    logic [3:0] exp_v;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    din = 2'b00;
    ld = '0;
    cin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset leaves all terms blown
    for (int v = 0; v < 4; v++) begin
      apply(2'(v));
      for (int d = 0; d < 3; d++)
        check("R6 reset map gives zero", 64'(dout[d]), 64'h0);
    end

    load_map(0, 64'(PLA_MAP), 48, rb);
    load_map(1, 64'(ROM_MAP), 16, rb);
    load_map(2, 64'(PAL_MAP), 32, rb);

    // Table walk: R1 literals, R2 two-plane, R4 decoder ROM, R3 fixed sum, R11 functions
    for (int i = 0; i < 4; i++) begin
      apply(VEC[i][5:4]);
      check("R2 R11 two-plane", 64'(dout[0]), 64'(VEC[i][3:0]));
      check("R4 R11 decoder ROM", 64'(dout[1]), 64'(VEC[i][3:0]));
      check("R1 R3 R11 fixed sum", 64'(dout[2]), 64'(VEC[i][3:0]));
    end

    // R10: serial input ignored with load low
    din = 2'b10;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      cin = 3'(c * 5 + 1);
      #1;
      check("R10 idle shifts ignored", 64'(dout[0]), 64'h7);
    end
    cin = '0;
    for (int i = 0; i < 4; i++) begin
      apply(VEC[i][5:4]);
      check("R10 map kept", 64'(dout[1]), 64'(VEC[i][3:0]));
    end

    // R9 readback and R5 contradictory term
    load_map(0, 64'(PLA_BAD), 48, rb);
    check("R9 readback of old map", rb, 64'(PLA_MAP));
    for (int v = 0; v < 4; v++) begin
      apply(2'(v));
      case (v)
        0: exp_v = 4'h2;
        1: exp_v = 4'h5;
        2: exp_v = 4'h7;
        default: exp_v = 4'h4;
      endcase
      check("R5 contradictory term zero", 64'(dout[0]), 64'(exp_v));
    end

    // R7: four extra zero shifts move every ROM word down one address
    load_map(1, 64'h0, 4, rb);
    check("R9 readback of dropped word", rb, 64'hA);
    for (int v = 0; v < 4; v++) begin
      apply(2'(v));
      case (v)
        0: exp_v = 4'hF;
        1: exp_v = 4'h7;
        2: exp_v = 4'h4;
        default: exp_v = 4'h0;
      endcase
      check("R7 shift order", 64'(dout[1]), 64'(exp_v));
    end

    // R8: mid-load outputs blank
    apply(2'b01);
    ld[2] = 1'b1;
    cin[2] = 1'b1;
    @(negedge clk);
    #1;
    check("R8 mid-load blank", 64'(dout[2]), 64'h0);
    ld[2] = 1'b0;
    #1;
    check("R8 output after load drop", 64'(dout[2]) != 64'h0 ? 64'h1 : 64'h0, 64'h1);

    // R6: reset in the middle of operation clears the map
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      apply(2'(v));
      check("R6 reset clears map", 64'(dout[0]), 64'h0);
    end

    finish_run();
  end
endmodule